// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block sits on the receive path of a slave node that runs from a fixed local clock. It watches the synchronised bus line and picks out the start of each frame header. A dominant run that lasts long enough is taken as the break. The block then waits through the recessive delimiter and receives two bytes in UART format. The first byte must hold the synchronisation pattern. The second is the protected identifier, whose two parity bits are checked before the 6-bit frame identifier is handed on.

Every outcome is reported by a one-cycle strobe. A good header raises `hdr_valid` and updates `frame_id`. A bad identifier parity raises `err_parity`, a wrong sync pattern raises `err_sync`, and a dominant stop bit raises `err_frame`. Breaks, delimiters and the gap between the bytes may all be stretched. Every bit is sampled at a fixed point within a narrow window after the start-bit edge. The bit time is given as a parameter in clock cycles.

Top module: `lin_hdr_rx`

## Requirements
- R1: A dominant (0) run of at least BRK_BITS bit times (default 11) is taken as a break. A shorter dominant run starts no header, so two bytes that follow it without a break produce no strobe.
- R2: A break that lasts anywhere from BRK_BITS up to 20 bit times is accepted, and the header that follows it is reported as valid.
- R3: Any recessive delimiter of 1 to 10 bit times after the break is accepted.
- R4: A recessive gap of 0 to 13 bit times between the sync byte and the identifier byte is accepted. This covers both nominal and maximum-length headers.
- R5: The sync byte, sent LSB first, must equal 0x55. Any other value gives one `err_sync` strobe, no `hdr_valid`, and reception stops until the next break.
- R6: The identifier byte carries the ID in bits 5:0. Bit 6 must equal ID0^ID1^ID2^ID4 and bit 7 must equal NOT(ID1^ID3^ID4^ID5). A mismatch gives one `err_parity` strobe and no `hdr_valid`.
- R7: A dominant stop bit on either header byte gives one `err_frame` strobe and no `hdr_valid`.
- R8: Each bit is sampled between 7/16 and 10/16 of a bit time into its cell, counted from the start-bit falling edge. A byte whose data bits hold their value only from 6/16 to 11/16 of each cell is still decoded correctly.
- R9: A break that arrives in the middle of a header abandons that header. The header that follows the new break is then received and reported with its own ID.
- R10: At most one of the four strobes is high in any cycle. `frame_id` changes only in the cycle in which `hdr_valid` is high.
- R11: While reset is asserted and right after it is released, all strobes are 0 and `frame_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Synchronised bus line, 1 = recessive |
| hdr_valid | output | 1 | One-cycle strobe for an accepted header |
| frame_id | output | 6 | ID of the last accepted header |
| err_parity | output | 1 | One-cycle strobe for an identifier parity mismatch |
| err_sync | output | 1 | One-cycle strobe for a wrong sync pattern |
| err_frame | output | 1 | One-cycle strobe for a dominant stop bit |

## Verification
The assertions check the following properties on every cycle:
- the strobes are mutually exclusive;
- `frame_id` moves only together with `hdr_valid`;
- every strobe comes from the sequencer state that owns it;
- a detected break always returns the sequencer to break handling;
- a break is flagged once per dominant run;
- the byte receiver reports only the bytes it was busy receiving.

Some behaviours can only be shown by the bench's scenarios, because they depend on whole waveforms. These are the break-length boundary, stretched delimiters and gaps, the parity and sync decoding, the narrow sampling window, and recovery from a break in mid-header.

// File: rtl/lin_hdr_pkg.sv
`timescale 1ns/1ps
package lin_hdr_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_BRK, ST_SYNC, ST_PID} hdr_st_e;

   localparam logic [7:0] SYNC_PATTERN = 8'h55;

   // returns {P1, P0} for a 6-bit identifier
   function automatic logic [1:0] id_parity(input logic [5:0] id);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0};
   endfunction
endpackage

// File: rtl/lin_brk_det.sv
`timescale 1ns/1ps
module lin_brk_det #(
   parameter int BRK_CYC = 176
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx,
   output logic brk
);
   localparam int CW = $clog2(BRK_CYC + 1);
   localparam logic [CW-1:0] HIT  = CW'(BRK_CYC - 1);
   localparam logic [CW-1:0] SATV = CW'(BRK_CYC);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         brk     <= 1'b0;
      end else begin
         if (rx)
            low_cnt <= '0;
         else if (low_cnt != SATV)
            low_cnt <= low_cnt + 1'b1;
         brk <= !rx && (low_cnt == HIT);
      end
   end

   // one flag per dominant run
   p_brk_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !brk);
endmodule

// File: rtl/lin_byte_rx.sv
`timescale 1ns/1ps
module lin_byte_rx #(
   parameter int BIT_CYC   = 16,
   parameter int SAMPLE_16 = 8,
   parameter bit MAJORITY  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       rx,
   output logic       done,
   output logic [7:0] data,
   output logic       stop_ok
);
   localparam int SMP    = BIT_CYC * SAMPLE_16 / 16;
   localparam int WIN_LO = (7 * BIT_CYC + 15) / 16;
   localparam int WIN_HI = (10 * BIT_CYC) / 16;
   localparam int MJ     = MAJORITY ? 1 : 0;
   localparam int EVAL   = MAJORITY ? SMP : SMP - 1;
   localparam int PH_W   = $clog2(BIT_CYC);
   localparam logic [PH_W-1:0] EVAL_V  = PH_W'(EVAL);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(BIT_CYC - 1);

   if (SMP - MJ < WIN_LO || SMP + MJ > WIN_HI || EVAL < 0) begin : g_bad_window
      $error("lin_byte_rx: sample point outside the 7/16..10/16 window");
   end

   logic bit_val;

   if (MAJORITY) begin : g_vote
      logic [1:0] hist;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist <= 2'b11;
         else        hist <= {hist[0], rx};
      end
      assign bit_val = (hist[1] & hist[0]) | (hist[1] & rx) | (hist[0] & rx);
   end else begin : g_single
      assign bit_val = rx;
   end

   logic            busy;
   logic [PH_W-1:0] phase;
   logic [3:0]      bitno;
   logic [7:0]      shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase   <= '0;
         bitno   <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         data    <= '0;
         stop_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            busy <= 1'b0;
         end else if (!busy) begin
            if (!rx) begin
               busy  <= 1'b1;
               phase <= '0;
               bitno <= '0;
            end
         end else begin
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
            if (phase == LAST_PH) bitno <= bitno + 1'b1;
            if (phase == EVAL_V) begin
               if (bitno == 4'd0) begin
                  if (bit_val) busy <= 1'b0;      // start bit not dominant
               end else if (bitno == 4'd9) begin
                  done    <= 1'b1;
                  data    <= shreg;
                  stop_ok <= bit_val;
                  busy    <= 1'b0;
               end else begin
                  shreg <= {bit_val, shreg[7:1]};
               end
            end
         end
      end
   end

   p_done_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy) && $past(en));
   p_bit_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bitno <= 4'd9);
endmodule

// File: rtl/lin_hdr_rx.sv
`timescale 1ns/1ps
module lin_hdr_rx
   import lin_hdr_pkg::*;
#(
   parameter int BIT_CYC   = 16,
   parameter int BRK_BITS  = 11,
   parameter int SAMPLE_16 = 8,
   parameter bit MAJORITY  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx,
   output logic       hdr_valid,
   output logic [5:0] frame_id,
   output logic       err_parity,
   output logic       err_sync,
   output logic       err_frame
);
   localparam int BRK_CYC = BRK_BITS * BIT_CYC;

   if (BIT_CYC < 8) begin : g_bad_bit
      $error("lin_hdr_rx: BIT_CYC must be at least 8");
   end
   if (BRK_BITS < 11) begin : g_bad_brk
      $error("lin_hdr_rx: BRK_BITS must be at least 11");
   end

   logic       rx_q;
   logic       brk_hit;
   logic       byte_done;
   logic [7:0] byte_data;
   logic       byte_stop;
   hdr_st_e    state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= 1'b1;
      else        rx_q <= rx;
   end

   lin_brk_det #(.BRK_CYC(BRK_CYC)) i_brk (
      .clk(clk), .rst_n(rst_n), .rx(rx_q), .brk(brk_hit)
   );

   lin_byte_rx #(.BIT_CYC(BIT_CYC), .SAMPLE_16(SAMPLE_16), .MAJORITY(MAJORITY)) i_byte (
      .clk(clk), .rst_n(rst_n),
      .en(state == ST_SYNC || state == ST_PID),
      .rx(rx_q), .done(byte_done), .data(byte_data), .stop_ok(byte_stop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         hdr_valid  <= 1'b0;
         frame_id   <= '0;
         err_parity <= 1'b0;
         err_sync   <= 1'b0;
         err_frame  <= 1'b0;
      end else begin
         hdr_valid  <= 1'b0;
         err_parity <= 1'b0;
         err_sync   <= 1'b0;
         err_frame  <= 1'b0;
         if (brk_hit) begin
            state <= ST_BRK;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_BRK:  if (rx_q) state <= ST_SYNC;
               ST_SYNC: if (byte_done) begin
                  if (!byte_stop) begin
                     err_frame <= 1'b1;
                     state     <= ST_IDLE;
                  end else if (byte_data != SYNC_PATTERN) begin
                     err_sync <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     state <= ST_PID;
                  end
               end
               ST_PID: if (byte_done) begin
                  state <= ST_IDLE;
                  if (!byte_stop)
                     err_frame <= 1'b1;
                  else if (byte_data[7:6] != id_parity(byte_data[5:0]))
                     err_parity <= 1'b1;
                  else begin
                     hdr_valid <= 1'b1;
                     frame_id  <= byte_data[5:0];
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hdr_valid, err_parity, err_sync, err_frame}));
   p_id_moves_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_id) |-> hdr_valid);
   p_break_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |=> state == ST_BRK);
   p_sync_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_sync |-> $past(state) == ST_SYNC);
   p_valid_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid || err_parity) |-> $past(state) == ST_PID);
endmodule

// File: tb/test_lin_hdr_rx.sv
`timescale 1ns/1ps
module test_lin_hdr_rx;
   localparam int B = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic hdr_valid, err_parity, err_sync, err_frame;
   logic [5:0] frame_id;

   always #5 clk = ~clk;

   lin_hdr_rx #(.BIT_CYC(B)) i_lin_hdr_rx (
      .clk(clk), .rst_n(rst_n), .rx(rx), .hdr_valid(hdr_valid),
      .frame_id(frame_id), .err_parity(err_parity), .err_sync(err_sync),
      .err_frame(err_frame)
   );

   int n_chk = 0, n_bad = 0;
   int c_v = 0, c_p = 0, c_s = 0, c_f = 0;

   always @(negedge clk) begin
      if (hdr_valid)  c_v++;
      if (err_parity) c_p++;
      if (err_sync)   c_s++;
      if (err_frame)  c_f++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pid_of(input logic [5:0] id, input logic flip);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1 ^ flip, p0, id};
   endfunction

   task automatic send_byte(input logic [7:0] b, input logic stop, input logic narrow);
      rx = 1'b0; tick(B);
      for (int i = 0; i < 8; i++) begin
         if (narrow) begin
            for (int c = 0; c < B; c++) begin
               rx = (c >= 6 && c < 11) ? b[i] : ~b[i];
               tick(1);
            end
         end else begin
            rx = b[i]; tick(B);
         end
      end
      rx = stop; tick(B);
      rx = 1'b1;
   endtask

   task automatic send_hdr(input int brk, input int del, input int gap, input logic [7:0] sy,
                           input logic [7:0] pid, input logic bstop, input logic narrow);
      rx = 1'b0; tick(brk * B);
      rx = 1'b1; tick(del * B);
      send_byte(sy, 1'b1, narrow);
      tick(gap * B);
      send_byte(pid, ~bstop, narrow);
      tick(4 * B);
   endtask

   typedef struct packed {
      logic [4:0] brk;
      logic [3:0] del;
      logic [3:0] gap;
      logic [7:0] sy;
      logic [5:0] id;
      logic       pflip;
      logic       bstop;
      logic       narrow;
      logic [1:0] code;   // 0 valid, 1 parity, 2 sync, 3 frame
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{5'd13, 4'd1,  4'd0,  8'h55, 6'h3C, 1'b0, 1'b0, 1'b0, 2'd0},  // R3 min delimiter
      '{5'd20, 4'd1,  4'd0,  8'h55, 6'h01, 1'b0, 1'b0, 1'b0, 2'd0},  // R2 20-bit break
      '{5'd11, 4'd1,  4'd0,  8'h55, 6'h15, 1'b0, 1'b0, 1'b0, 2'd0},  // R1 break at boundary
      '{5'd13, 4'd10, 4'd0,  8'h55, 6'h2A, 1'b0, 1'b0, 1'b0, 2'd0},  // R3 10-bit delimiter
      '{5'd13, 4'd1,  4'd13, 8'h55, 6'h3F, 1'b0, 1'b0, 1'b0, 2'd0},  // R4 13-bit gap
      '{5'd19, 4'd2,  4'd6,  8'h55, 6'h10, 1'b0, 1'b0, 1'b0, 2'd0},  // R4 maximum header
      '{5'd13, 4'd1,  4'd0,  8'h54, 6'h05, 1'b0, 1'b0, 1'b0, 2'd2},  // R5 wrong sync
      '{5'd13, 4'd1,  4'd0,  8'hD5, 6'h05, 1'b0, 1'b0, 1'b0, 2'd2},  // R5 top bit wrong
      '{5'd13, 4'd1,  4'd0,  8'h55, 6'h22, 1'b1, 1'b0, 1'b0, 2'd1},  // R6 bad parity
      '{5'd13, 4'd1,  4'd0,  8'h55, 6'h19, 1'b0, 1'b1, 1'b0, 2'd3},  // R7 dominant stop
      '{5'd13, 4'd1,  4'd0,  8'h55, 6'h0B, 1'b0, 1'b0, 1'b1, 2'd0}   // R8 narrow window
   };

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v0, p0, s0, f0;
      tick(3);
      chk(!hdr_valid && !err_parity && !err_sync && !err_frame, "R11 strobes in reset",
          {hdr_valid, err_parity, err_sync, err_frame}, 0);
      rst_n = 1'b1;
      tick(2);
      chk(frame_id == 6'd0, "R11 frame_id after reset", frame_id, 0);
      chk(c_v + c_p + c_s + c_f == 0, "R11 no strobe after reset", c_v + c_p + c_s + c_f, 0);

      for (int k = 0; k < NV; k++) begin
         vec_t t;
         t = VECS[k];
         v0 = c_v; p0 = c_p; s0 = c_s; f0 = c_f;
         send_hdr(int'(t.brk), int'(t.del), int'(t.gap), t.sy, pid_of(t.id, t.pflip),
                  t.bstop, t.narrow);
         chk(c_v - v0 == (t.code == 2'd0 ? 1 : 0), "R2 R3 R4 R8 valid count", c_v - v0,
             t.code == 2'd0 ? 1 : 0);
         chk(c_p - p0 == (t.code == 2'd1 ? 1 : 0), "R6 parity count", c_p - p0,
             t.code == 2'd1 ? 1 : 0);
         chk(c_s - s0 == (t.code == 2'd2 ? 1 : 0), "R5 sync count", c_s - s0,
             t.code == 2'd2 ? 1 : 0);
         chk(c_f - f0 == (t.code == 2'd3 ? 1 : 0), "R7 frame count", c_f - f0,
             t.code == 2'd3 ? 1 : 0);
         if (t.code == 2'd0)
            chk(frame_id == t.id, "R6 frame_id", frame_id, t.id);
      end

      // R1: a 10-bit dominant run is not a break; bytes after it are ignored
      v0 = c_v; p0 = c_p; s0 = c_s; f0 = c_f;
      rx = 1'b0; tick(10 * B);
      rx = 1'b1; tick(2 * B);
      send_byte(8'h55, 1'b1, 1'b0);
      send_byte(pid_of(6'h07, 1'b0), 1'b1, 1'b0);
      tick(4 * B);
      chk((c_v - v0) + (c_p - p0) + (c_s - s0) + (c_f - f0) == 0, "R1 short run no header",
          (c_v - v0) + (c_p - p0) + (c_s - s0) + (c_f - f0), 0);
      chk(frame_id == 6'h0B, "R1 frame_id kept", frame_id, 6'h0B);

      // R9: a new break during the gap before the identifier restarts reception
      v0 = c_v; p0 = c_p; s0 = c_s;
      rx = 1'b0; tick(13 * B);
      rx = 1'b1; tick(B);
      send_byte(8'h55, 1'b1, 1'b0);
      tick(2 * B);
      send_hdr(13, 1, 0, 8'h55, pid_of(6'h2C, 1'b0), 1'b0, 1'b0);
      chk(c_v - v0 == 1, "R9 valid after restart", c_v - v0, 1);
      chk(frame_id == 6'h2C, "R9 frame_id after restart", frame_id, 6'h2C);
      chk((c_p - p0) + (c_s - s0) == 0, "R9 no parity or sync report",
          (c_p - p0) + (c_s - s0), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule